// File: doc/BRIEF.md
# Decoded-Error Bit Flipper

This block finishes a page read that has already been through an error-correcting decoder. It is started with the decoder's captured status word. It reads the error count from that word and walks the reported bit positions in order. Each faulty bit is repaired in a byte-wide page buffer with a read-modify-write. Positions arrive two per 32-bit index word. The block fetches a new index word for every even-numbered error and reuses the word it holds for the odd-numbered one that follows.

Some pages need no repair. A page the decoder found to be entirely erased, or entirely zero, is left untouched and reported as blank. A page the decoder could not correct is also left untouched and reported as failed. A position whose byte lies at or beyond the configured data length is skipped and raises a range flag. The caller then sees a one-cycle done pulse and result flags that hold until the next start.

Top module: `ecc_bitfix`

## Requirements
- R1: The error count is status bits [31:28], so 0 to 15 positions are processed. Status bits other than [31:28], 5, 4 and 1 have no effect.
- R2: Index word j holds position 2j in bits [12:0] and position 2j+1 in bits [28:16]. Bits [15:13] and [31:29] are ignored. Before each even-numbered position, one index read is issued at address k/2. The index port returns the data one cycle after the read.
- R3: For a position p, the byte at address p>>3 gets bit p[2:0] inverted, and no other bit changes. Positions are applied in order, so a bit reported twice ends up unchanged.
- R4: If status bit 5 (all-ones page) or bit 4 (all-zero page) is set, no RAM write occurs, blank_o is 1 and fail_o is 0.
- R5: If status bit 1 (uncorrectable) is set and neither blank bit is set, no RAM write occurs and fail_o is 1. A blank bit wins over bit 1.
- R6: Each flip is a read cycle (ram_en_o=1, ram_we_o=0), followed in the next cycle by a write to the same address. The write data is the RAM read data XOR the bit mask. The RAM returns read data one cycle after the read.
- R7: done_o is high for exactly one cycle. For an active run, each even-numbered position takes 3 cycles, each odd-numbered one takes 1 cycle, and each in-range flip adds 1 write cycle. done_o rises in the cycle after the last of these. blank_o, fail_o and range_o hold from the start until the next start.
- R8: A position whose byte address is at or above data_len_i makes no RAM access and sets range_o. The remaining positions are still processed.
- R9: With a count of 0 and no blank or uncorrectable bit, and with any bypass, done_o is high in the cycle right after start is sampled, with no index or RAM access.
- R10: start_i is ignored while a run is in progress.
- R11: After reset, done_o, idx_rd_o, ram_en_o, ram_we_o, blank_o, fail_o and range_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run when idle |
| status_i | input | 32 | Decoder status word, sampled with start |
| data_len_i | input | ADDR_W+1 | Number of valid bytes in the page buffer |
| idx_rd_o | output | 1 | Index word read strobe |
| idx_addr_o | output | 3 | Index word address |
| idx_data_i | input | 32 | Index word, valid one cycle after the read |
| ram_en_o | output | 1 | Page buffer access enable |
| ram_we_o | output | 1 | Page buffer write (with ram_en_o) |
| ram_addr_o | output | ADDR_W | Page buffer byte address |
| ram_wdata_o | output | 8 | Byte written back |
| ram_rdata_i | input | 8 | Byte read, valid one cycle after the read |
| done_o | output | 1 | One-cycle completion pulse |
| blank_o | output | 1 | Run bypassed as a blank page |
| fail_o | output | 1 | Run reported uncorrectable |
| range_o | output | 1 | At least one position was out of range |

## Verification
The bench builds the block with ADDR_W=10, so the 1024-byte buffer covers every byte a 13-bit position can name. Position 8191 therefore hits the top byte and bit 7. With data_len_i lowered to 200, the bench reaches the range boundary at bytes 199 and 200. Index words carry junk in their unused bits, and the status words carry junk in their undecoded bits. A full run of 15 positions fills every index address. Repeated positions show that the read-modify-writes are applied in order.

// File: rtl/ecc_bitfix_pkg.sv
package ecc_bitfix_pkg;
  // status word decode
  localparam int STAT_W    = 32;
  localparam int CNT_LSB   = 28;
  localparam int CNT_W     = 4;
  localparam int ONES_BIT  = 5;
  localparam int ZERO_BIT  = 4;
  localparam int UNCOR_BIT = 1;
  // index word decode
  localparam int IDX_W     = 32;
  localparam int POS_W     = 13;
  localparam int LO_LSB    = 0;
  localparam int HI_LSB    = 16;
  localparam int IDX_AW    = CNT_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WORD,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } fix_state_t;
endpackage

// File: rtl/ecc_bitfix_locate.sv
// Picks one packed position and turns it into a byte address, bit mask and range verdict.
module ecc_bitfix_locate
  import ecc_bitfix_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [IDX_W-1:0]  word_i,
  input  logic              odd_i,
  input  logic [ADDR_W:0]   len_i,
  output logic [ADDR_W-1:0] byte_o,
  output logic [7:0]        mask_o,
  output logic              in_range_o
);
  localparam int BYTE_W = POS_W - 3;
  localparam int CMP_W  = (BYTE_W > ADDR_W + 1) ? BYTE_W : ADDR_W + 1;

  logic [POS_W-1:0]  pos;
  logic [BYTE_W-1:0] byte_full;
  logic [CMP_W-1:0]  byte_ext;
  logic [CMP_W-1:0]  len_ext;
  logic              unused_word;

  assign pos        = odd_i ? word_i[HI_LSB +: POS_W] : word_i[LO_LSB +: POS_W];
  assign byte_full  = pos[POS_W-1:3];
  assign byte_ext   = CMP_W'(byte_full);
  assign len_ext    = CMP_W'(len_i);
  assign in_range_o = byte_ext < len_ext;
  assign byte_o     = ADDR_W'(byte_full);
  assign mask_o     = 8'b1 << pos[2:0];
  assign unused_word = ^word_i;
endmodule

// File: rtl/ecc_bitfix_ctrl.sv
// Run sequencer: status decode, index fetch and read-modify-write of the page buffer.
module ecc_bitfix_ctrl
  import ecc_bitfix_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [ADDR_W-1:0] loc_byte_i,
  input  logic [7:0]        loc_mask_i,
  input  logic              loc_ok_i,
  output logic [IDX_W-1:0]  word_o,
  output logic              odd_o,
  output logic              idx_rd_o,
  output logic [IDX_AW-1:0] idx_addr_o,
  input  logic [IDX_W-1:0]  idx_data_i,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              done_o,
  output logic              blank_o,
  output logic              fail_o,
  output logic              range_o
);
  fix_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  k_q, k_d, k_inc;
  logic [IDX_W-1:0]  word_q, word_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        mask_q, mask_d;
  logic              blank_q, blank_d;
  logic              fail_q, fail_d;
  logic              range_q, range_d;
  logic              advance;
  logic              upd;
  logic              st_blank;
  logic              st_uncor;
  logic [CNT_W-1:0]  st_cnt;
  logic              unused_status;

  assign st_blank      = status_i[ONES_BIT] | status_i[ZERO_BIT];
  assign st_uncor      = status_i[UNCOR_BIT];
  assign st_cnt        = status_i[CNT_LSB +: CNT_W];
  assign unused_status = ^status_i;
  assign k_inc         = k_q + 1'b1;
  assign upd           = start_i | (state_q != ST_IDLE);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    k_d         = k_q;
    word_d      = word_q;
    addr_d      = addr_q;
    mask_d      = mask_q;
    blank_d     = blank_q;
    fail_d      = fail_q;
    range_d     = range_q;
    advance     = 1'b0;
    idx_rd_o    = 1'b0;
    ram_en_o    = 1'b0;
    ram_we_o    = 1'b0;
    ram_addr_o  = addr_q;
    ram_wdata_o = ram_rdata_i ^ mask_q;
    done_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cnt_d   = st_cnt;
          k_d     = '0;
          blank_d = st_blank;
          fail_d  = ~st_blank & st_uncor;
          range_d = 1'b0;
          if (st_blank || st_uncor || (st_cnt == '0)) state_d = ST_DONE;
          else                                        state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        idx_rd_o = 1'b1;
        state_d  = ST_WORD;
      end
      ST_WORD: begin
        word_d  = idx_data_i;
        state_d = ST_READ;
      end
      ST_READ: begin
        if (loc_ok_i) begin
          ram_en_o   = 1'b1;
          ram_addr_o = loc_byte_i;
          addr_d     = loc_byte_i;
          mask_d     = loc_mask_i;
          state_d    = ST_WRITE;
        end else begin
          range_d = 1'b1;
          advance = 1'b1;
        end
      end
      ST_WRITE: begin
        ram_en_o = 1'b1;
        ram_we_o = 1'b1;
        advance  = 1'b1;
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (advance) begin
      k_d = k_inc;
      if (k_inc == cnt_q) state_d = ST_DONE;
      else if (!k_inc[0]) state_d = ST_FETCH;
      else                state_d = ST_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      k_q     <= '0;
      word_q  <= '0;
      addr_q  <= '0;
      mask_q  <= '0;
      blank_q <= 1'b0;
      fail_q  <= 1'b0;
      range_q <= 1'b0;
    end else if (upd) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      k_q     <= k_d;
      word_q  <= word_d;
      addr_q  <= addr_d;
      mask_q  <= mask_d;
      blank_q <= blank_d;
      fail_q  <= fail_d;
      range_q <= range_d;
    end
  end

  assign word_o     = word_q;
  assign odd_o      = k_q[0];
  assign idx_addr_o = k_q[CNT_W-1:1];
  assign blank_o    = blank_q;
  assign fail_o     = fail_q;
  assign range_o    = range_q;
endmodule

// File: rtl/ecc_bitfix.sv
module ecc_bitfix
  import ecc_bitfix_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       status_i,
  input  logic [ADDR_W:0]   data_len_i,
  output logic              idx_rd_o,
  output logic [2:0]        idx_addr_o,
  input  logic [31:0]       idx_data_i,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              done_o,
  output logic              blank_o,
  output logic              fail_o,
  output logic              range_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [IDX_W-1:0]  word;
  logic              odd;
  logic [ADDR_W-1:0] loc_byte;
  logic [7:0]        loc_mask;
  logic              loc_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ecc_bitfix_locate #(.ADDR_W(ADDR_W)) u_locate (
    .word_i     (word),
    .odd_i      (odd),
    .len_i      (data_len_i),
    .byte_o     (loc_byte),
    .mask_o     (loc_mask),
    .in_range_o (loc_ok)
  );

  ecc_bitfix_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .status_i    (status_i),
    .loc_byte_i  (loc_byte),
    .loc_mask_i  (loc_mask),
    .loc_ok_i    (loc_ok),
    .word_o      (word),
    .odd_o       (odd),
    .idx_rd_o    (idx_rd_o),
    .idx_addr_o  (idx_addr_o),
    .idx_data_i  (idx_data_i),
    .ram_en_o    (ram_en_o),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_rdata_i (ram_rdata_i),
    .done_o      (done_o),
    .blank_o     (blank_o),
    .fail_o      (fail_o),
    .range_o     (range_o)
  );
endmodule

// File: rtl/ecc_bitfix_chk.sv
module ecc_bitfix_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idx_rd_o,
  input logic              ram_en_o,
  input logic              ram_we_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic [ADDR_W:0]   data_len_i,
  input logic              done_o,
  input logic              blank_o,
  input logic              fail_o
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_no_write_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (!blank_o && !fail_o));

  p_write_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> ram_en_o);

  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> $past(ram_en_o && !ram_we_o));

  p_write_same_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> (ram_addr_o == $past(ram_addr_o)));

  p_access_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en_o |-> ({1'b0, ram_addr_o} < data_len_i));

  p_fetch_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rd_o |=> !idx_rd_o);

  p_no_access_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ram_en_o && !idx_rd_o));
endmodule

bind ecc_bitfix ecc_bitfix_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idx_rd_o   (idx_rd_o),
  .ram_en_o   (ram_en_o),
  .ram_we_o   (ram_we_o),
  .ram_addr_o (ram_addr_o),
  .data_len_i (data_len_i),
  .done_o     (done_o),
  .blank_o    (blank_o),
  .fail_o     (fail_o)
);

// File: tb/ecc_bitfix_tb.sv
`timescale 1ns/1ps
module ecc_bitfix_tb;
  localparam int ADDR_W = 10;
  localparam int NBYTE  = 1 << ADDR_W;
  localparam real TCK   = 8.0;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [31:0]       status_i;
  logic [ADDR_W:0]   data_len_i;
  logic              idx_rd_o;
  logic [2:0]        idx_addr_o;
  logic [31:0]       idx_data_i;
  logic              ram_en_o;
  logic              ram_we_o;
  logic [ADDR_W-1:0] ram_addr_o;
  logic [7:0]        ram_wdata_o;
  logic [7:0]        ram_rdata_i;
  logic              done_o;
  logic              blank_o;
  logic              fail_o;
  logic              range_o;

  int n_chk;
  int n_bad;

  logic [7:0]  ram     [NBYTE];
  logic [7:0]  exp_mem [NBYTE];
  logic [31:0] idxmem  [8];
  logic        fill;

  ecc_bitfix #(.ADDR_W(ADDR_W)) u_dut (.*);

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // page buffer and index memory models, one-cycle read latency
  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < NBYTE; i++) ram[i] <= pat(i);
    end else if (ram_en_o) begin
      if (ram_we_o) ram[ram_addr_o] <= ram_wdata_o;
      else          ram_rdata_i <= ram[ram_addr_o];
    end
    if (idx_rd_o) idx_data_i <= idxmem[idx_addr_o];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // junk in the unused bits of each index word
  function automatic logic [31:0] mkw(input int p0, input int p1);
    return {3'b101, 13'(p1), 3'b110, 13'(p0)};
  endfunction

  // junk in undecoded status bits
  function automatic logic [31:0] mks(input int cnt, input logic [7:0] flags);
    return {4'(cnt), 28'h0FF_00C0} | {24'h0, flags & 8'h32};
  endfunction

  task automatic run(input logic [31:0] st, input int len, input bit restart,
                     input string req);
    int          cnt, s_exp, n, p, b, got, e;
    bit          blk, unc, rng, done_seen;
    logic [31:0] w;
    int          wq[$];
    int          fq[$];
    int          mism;
    cnt = int'(st[31:28]);
    blk = st[5] | st[4];
    unc = st[1] & !blk;
    rng = 0;
    s_exp = 0;
    if (!blk && !unc) begin
      for (int k = 0; k < cnt; k++) begin
        w = idxmem[k / 2];
        p = (k % 2 == 1) ? int'(w[28:16]) : int'(w[12:0]);
        if (k % 2 == 0) begin s_exp += 3; fq.push_back(k / 2); end
        else s_exp += 1;
        b = p / 8;
        if (b < len) begin
          s_exp += 1;
          exp_mem[b] = exp_mem[b] ^ (8'd1 << (p % 8));
          wq.push_back(b * 256 + int'(exp_mem[b]));
        end else rng = 1;
      end
    end
    @(negedge clk);
    data_len_i = (ADDR_W+1)'(len);
    status_i   = st;
    start_i    = 1'b1;
    n = 0;
    done_seen = 0;
    while (!done_seen && n < s_exp + 20) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start_i = restart && (n == 2);
      if (restart && n == 2) status_i = mks(15, 8'h30);
      if (ram_en_o && ram_we_o) begin
        got = int'(ram_addr_o) * 256 + int'(ram_wdata_o);
        if (wq.size() == 0) chk(0, "R3", "unexpected write", got, -1);
        else begin e = wq.pop_front(); chk(got == e, "R6", "write addr/data", got, e); end
      end
      if (idx_rd_o) begin
        if (fq.size() == 0) chk(0, "R2", "unexpected index read", idx_addr_o, -1);
        else begin e = fq.pop_front(); chk(int'(idx_addr_o) == e, "R2", "index address", idx_addr_o, e); end
      end
      if (done_o) done_seen = 1;
    end
    start_i = 1'b0;
    chk(done_seen && n == s_exp + 1, {req, "/R7"}, "done cycle", n, s_exp + 1);
    chk(blank_o == blk, {req, "/R4"}, "blank_o", blank_o, blk);
    chk(fail_o == unc, {req, "/R5"}, "fail_o", fail_o, unc);
    chk(range_o == rng, {req, "/R8"}, "range_o", range_o, rng);
    chk(wq.size() == 0 && fq.size() == 0, {req, "/R1"}, "missing accesses",
        wq.size() + fq.size(), 0);
    @(negedge clk);
    chk(!done_o, {req, "/R7"}, "done width", done_o, 0);
    chk(blank_o == blk && fail_o == unc && range_o == rng, {req, "/R7"}, "flags held",
        {blank_o, fail_o, range_o}, {blk, unc, rng});
    mism = 0;
    for (int i = 0; i < NBYTE; i++) if (ram[i] !== exp_mem[i]) mism++;
    chk(mism == 0, {req, "/R3"}, "buffer bytes differing", mism, 0);
  endtask

  initial begin
    #(TCK * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start_i = 1'b0; status_i = '0; data_len_i = '0; fill = 1'b1;
    for (int i = 0; i < NBYTE; i++) exp_mem[i] = pat(i);
    for (int i = 0; i < 8; i++) idxmem[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fill = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!done_o && !idx_rd_o && !ram_en_o && !ram_we_o, "R11", "control outputs",
        {done_o, idx_rd_o, ram_en_o, ram_we_o}, 0);
    chk(!blank_o && !fail_o && !range_o, "R11", "flags", {blank_o, fail_o, range_o}, 0);

    // R1/R2/R3: four positions incl. byte 0 bit 0 and top byte bit 7
    idxmem[0] = mkw(0, 8191);
    idxmem[1] = mkw(100, 4000);
    run(mks(4, 8'h00), NBYTE, 0, "R1");
    // R3: full count, repeats in one bit and one byte
    idxmem[0] = mkw(77, 77);
    idxmem[1] = mkw(80, 81);
    idxmem[2] = mkw(82, 7);
    idxmem[3] = mkw(1234, 5000);
    idxmem[4] = mkw(6000, 6001);
    idxmem[5] = mkw(7777, 3);
    idxmem[6] = mkw(2047, 2048);
    idxmem[7] = mkw(999, 0);
    run(mks(15, 8'h00), NBYTE, 0, "R3");
    // R1: single odd count
    idxmem[0] = mkw(555, 8191);
    run(mks(1, 8'h00), NBYTE, 0, "R1");
    // R4: blank pages
    run(mks(3, 8'h20), NBYTE, 0, "R4");
    run(mks(3, 8'h10), NBYTE, 0, "R4");
    // R5: uncorrectable, and blank priority
    run(mks(5, 8'h02), NBYTE, 0, "R5");
    run(mks(5, 8'h12), NBYTE, 0, "R5");
    // R9: zero count
    run(mks(0, 8'h00), NBYTE, 0, "R9");
    // R8: range boundary at byte 200
    idxmem[0] = mkw(199 * 8 + 3, 1600);
    idxmem[1] = mkw(8000, 12);
    run(mks(4, 8'h00), 200, 0, "R8");
    // R10: start during a run is ignored
    idxmem[0] = mkw(40, 41);
    idxmem[1] = mkw(300, 301);
    run(mks(3, 8'h00), NBYTE, 1, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule